// File: doc/BRIEF.md
# Masked Status Register Write Unit

This block holds the machine status word, the interrupt-pending and interrupt-enable words, a supervisor trap vector and a host mailbox. Every write goes through a per-register mask, so that only the fields a register allows to change can change. The privilege-level fields and the paging-mode field are also checked for legality, and a field that is given an illegal value keeps its old value. The top bit of the status word is never written directly. It always reflects whether the floating-point or the extension state field reports dirty.

A supervisor view of the status word and supervisor views of the pending and enable words are aliases of the machine registers. A supervisor write changes only the machine fields that the view exposes. A supervisor read shows only the supervisor bits. Writes take one strobe cycle and show up on the next clock edge. Reads are combinational from the current register state. A read of an address the block does not implement raises an illegal-access flag and returns zero.

Top module: `csrw_unit`

## Requirements
- R1: After reset the status word holds machine level (3) in bits [2:1] and supervisor level (1) in both bits [5:4] and bits [8:7]. All other status bits are 0, and the pending, enable, trap-vector and host registers read 0.
- R2: Each 2-bit privilege field of the status word (bits [2:1], [5:4], [8:7]) takes a written value only if that value is 0 (user), 1 (supervisor) or 3 (machine). A written value of 2 leaves that field unchanged, while the other fields of the same write still update.
- R3: The 5-bit paging-mode field (bits [21:17]) accepts 0 (bare) at every width. It accepts 8 only when XLEN is 32, and 9 or 10 only when XLEN is 64. Any other written value leaves the field unchanged.
- R4: Status bit XLEN-1 reads 1 exactly when the 2-bit field at [13:12] or the 2-bit field at [15:14] equals 3. A write to that bit itself has no effect.
- R5: A write to the machine pending word (address 0x108) changes only bits 1, 3 and 5. Bit 7 and all other bits stay 0.
- R6: A write to the machine enable word (address 0x104) changes only bits 1, 3, 5 and 7.
- R7: A write to the supervisor pending view (0x018) changes only pending bit 1. A write to the supervisor enable view (0x014) changes only enable bits 1 and 5. Reads of either view return only bits 1 and 5 of the underlying word.
- R8: The supervisor status view (0x010) maps its bit 0 to status IE (bit 0) and its bit 3 to status IE1 (bit 3). Its bit 4 maps to status PRV1 (bits [5:4], with the upper bit written 0). Bits [13:12], [15:14], 16 and XLEN-1 are shared with the status word. On a read, every other bit is 0.
- R9: A write to the supervisor trap vector (0x01C) stores the data with bits [1:0] cleared.
- R10: The host mailbox (0x120) accepts a write only while its current value is zero. Otherwise the write is ignored.
- R11: A read of any address other than 0x100, 0x104, 0x108, 0x120, 0x010, 0x014, 0x018 or 0x01C sets the illegal flag and returns zero. A read of an implemented address clears the flag.
- R12: With HAS_EXT set, the extension state field [15:14] is writable through both the machine and the supervisor status views.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Register address for the write |
| wr_data | input | XLEN | Write data |
| rd_addr | input | 12 | Register address for the read |
| rd_data | output | XLEN | Read data, combinational |
| rd_illegal | output | 1 | Read address is not implemented |

## Verification
On every cycle the checker confirms the following:
- No privilege field ever holds the value 2.
- The paging-mode field always holds a value that is legal for the width.
- The dirty summary bit matches the two state fields.
- The pending and enable words never carry a bit outside their writable masks.
- The trap vector's low bits stay zero.
- A nonzero mailbox never changes.
- An illegal read returns zero.

Only the bench's scenarios can show the rest:
- An illegal field value is dropped while the other fields of the same write still land.
- The supervisor views alias exactly the right machine bits in both directions.
- A view write leaves the bits outside its mask untouched.

// File: rtl/csrw_pkg.sv
package csrw_pkg;

    localparam logic [11:0] A_MSTATUS = 12'h100;
    localparam logic [11:0] A_MENABLE = 12'h104;
    localparam logic [11:0] A_MPEND   = 12'h108;
    localparam logic [11:0] A_HOST    = 12'h120;
    localparam logic [11:0] A_SSTATUS = 12'h010;
    localparam logic [11:0] A_SENABLE = 12'h014;
    localparam logic [11:0] A_SPEND   = 12'h018;
    localparam logic [11:0] A_STVEC   = 12'h01C;

    // status word field positions
    localparam int B_IE   = 0;
    localparam int B_PRV  = 1;
    localparam int B_IE1  = 3;
    localparam int B_PRV1 = 4;
    localparam int B_IE2  = 6;
    localparam int B_PRV2 = 7;
    localparam int B_FS   = 12;
    localparam int B_XS   = 14;
    localparam int B_MPRV = 16;
    localparam int B_VM   = 17;
    localparam int VM_W   = 5;

    // supervisor status view positions that differ from the machine word
    localparam int S_PIE = 3;
    localparam int S_PS  = 4;

    localparam logic [1:0] PRV_USER = 2'd0;
    localparam logic [1:0] PRV_SUP  = 2'd1;
    localparam logic [1:0] PRV_MACH = 2'd3;

    localparam logic [VM_W-1:0] VM_BARE = 5'd0;
    localparam logic [VM_W-1:0] VM_PG32 = 5'd8;
    localparam logic [VM_W-1:0] VM_PG39 = 5'd9;
    localparam logic [VM_W-1:0] VM_PG48 = 5'd10;

    // interrupt bit positions
    localparam int IRQ_W   = 8;
    localparam int IRQ_SSW = 1;
    localparam int IRQ_MSW = 3;
    localparam int IRQ_STM = 5;
    localparam int IRQ_MTM = 7;

    localparam logic [IRQ_W-1:0] PEND_WM   = (IRQ_W'(1) << IRQ_SSW) | (IRQ_W'(1) << IRQ_MSW)
                                           | (IRQ_W'(1) << IRQ_STM);
    localparam logic [IRQ_W-1:0] EN_WM     = PEND_WM | (IRQ_W'(1) << IRQ_MTM);
    localparam logic [IRQ_W-1:0] S_PEND_WM = IRQ_W'(1) << IRQ_SSW;
    localparam logic [IRQ_W-1:0] S_VIEW_M  = (IRQ_W'(1) << IRQ_SSW) | (IRQ_W'(1) << IRQ_STM);

    function automatic logic prv_ok(input logic [1:0] p);
        return (p == PRV_USER) || (p == PRV_SUP) || (p == PRV_MACH);
    endfunction

endpackage

// File: rtl/csrw_status_fix.sv
module csrw_status_fix
    import csrw_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] val,
    output logic [XLEN-1:0] nxt
);

    logic [VM_W-1:0] vm_new;
    logic            vm_ok;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] merged;

    assign vm_new = val[B_VM +: VM_W];

    generate
        if (XLEN == 32) begin : g_vm32
            assign vm_ok = (vm_new == VM_BARE) || (vm_new == VM_PG32);
        end else begin : g_vm64
            assign vm_ok = (vm_new == VM_BARE) || (vm_new == VM_PG39) || (vm_new == VM_PG48);
        end
    endgenerate

    always_comb begin
        mask = '0;
        mask[B_IE]   = 1'b1;
        mask[B_IE1]  = 1'b1;
        mask[B_IE2]  = 1'b1;
        mask[B_MPRV] = 1'b1;
        mask[B_FS +: 2] = 2'b11;
        if (HAS_EXT) mask[B_XS +: 2] = 2'b11;
        if (vm_ok) mask[B_VM +: VM_W] = '1;
        if (prv_ok(val[B_PRV  +: 2])) mask[B_PRV  +: 2] = 2'b11;
        if (prv_ok(val[B_PRV1 +: 2])) mask[B_PRV1 +: 2] = 2'b11;
        if (prv_ok(val[B_PRV2 +: 2])) mask[B_PRV2 +: 2] = 2'b11;
        merged = (cur & ~mask) | (val & mask);
        merged[XLEN-1] = (merged[B_FS +: 2] == 2'b11) || (merged[B_XS +: 2] == 2'b11);
        nxt = merged;
    end

endmodule

// File: rtl/csrw_sview.sv
module csrw_sview
    import csrw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] mstat,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] wr_full,
    output logic [XLEN-1:0] rd_view
);

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // supervisor write expressed as a full machine status value
    always_comb begin
        wr_full = mstat;
        wr_full[B_IE]        = wdata[B_IE];
        wr_full[B_IE1]       = wdata[S_PIE];
        wr_full[B_PRV1 +: 2] = {1'b0, wdata[S_PS]};
        wr_full[B_FS +: 2]   = wdata[B_FS +: 2];
        wr_full[B_XS +: 2]   = wdata[B_XS +: 2];
        wr_full[B_MPRV]      = wdata[B_MPRV];
    end

    always_comb begin
        rd_view = '0;
        rd_view[B_IE]      = mstat[B_IE];
        rd_view[S_PIE]     = mstat[B_IE1];
        rd_view[S_PS]      = mstat[B_PRV1];
        rd_view[B_FS +: 2] = mstat[B_FS +: 2];
        rd_view[B_XS +: 2] = mstat[B_XS +: 2];
        rd_view[B_MPRV]    = mstat[B_MPRV];
        rd_view[XLEN-1]    = mstat[XLEN-1];
    end

endmodule

// File: rtl/csrw_read_mux.sv
module csrw_read_mux
    import csrw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0]      addr,
    input  logic [XLEN-1:0]  mstat,
    input  logic [XLEN-1:0]  sstat,
    input  logic [IRQ_W-1:0] ie,
    input  logic [IRQ_W-1:0] ip,
    input  logic [XLEN-1:0]  tvec,
    input  logic [XLEN-1:0]  host,
    output logic [XLEN-1:0]  data,
    output logic             illegal
);

    localparam int PADW = XLEN - IRQ_W;

    always_comb begin
        data    = '0;
        illegal = 1'b0;
        case (addr)
            A_MSTATUS: data = mstat;
            A_SSTATUS: data = sstat;
            A_MENABLE: data = {{PADW{1'b0}}, ie};
            A_MPEND:   data = {{PADW{1'b0}}, ip};
            A_SENABLE: data = {{PADW{1'b0}}, ie & S_VIEW_M};
            A_SPEND:   data = {{PADW{1'b0}}, ip & S_VIEW_M};
            A_STVEC:   data = tvec;
            A_HOST:    data = host;
            default:   illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/csrw_unit.sv
module csrw_unit
    import csrw_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [11:0]     wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [11:0]     rd_addr,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_illegal
);

    localparam logic [XLEN-1:0] RST_STATUS = (XLEN'(PRV_MACH) << B_PRV)
                                           | (XLEN'(PRV_SUP) << B_PRV1)
                                           | (XLEN'(PRV_SUP) << B_PRV2);

    typedef struct packed {
        logic [XLEN-1:0]  status;
        logic [IRQ_W-1:0] ie;
        logic [IRQ_W-1:0] ip;
        logic [XLEN-1:0]  tvec;
        logic [XLEN-1:0]  host;
    } csr_state_t;

    csr_state_t st_d, st_q;

    logic [XLEN-1:0]  status_q, tvec_q, host_q;
    logic [IRQ_W-1:0] ie_q, ip_q;
    logic [XLEN-1:0]  m_fix, s_full, s_fix, s_view;

    assign status_q = st_q.status;
    assign tvec_q   = st_q.tvec;
    assign host_q   = st_q.host;
    assign ie_q     = st_q.ie;
    assign ip_q     = st_q.ip;

    csrw_status_fix #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_fix_m (
        .cur(status_q), .val(wr_data), .nxt(m_fix)
    );

    csrw_sview #(.XLEN(XLEN)) u_sview (
        .mstat(status_q), .wdata(wr_data), .wr_full(s_full), .rd_view(s_view)
    );

    csrw_status_fix #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_fix_s (
        .cur(status_q), .val(s_full), .nxt(s_fix)
    );

    csrw_read_mux #(.XLEN(XLEN)) u_rd (
        .addr(rd_addr), .mstat(status_q), .sstat(s_view), .ie(ie_q), .ip(ip_q),
        .tvec(tvec_q), .host(host_q), .data(rd_data), .illegal(rd_illegal)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_MSTATUS: st_d.status = m_fix;
                A_SSTATUS: st_d.status = s_fix;
                A_MPEND:   st_d.ip = (st_q.ip & ~PEND_WM)   | (wr_data[IRQ_W-1:0] & PEND_WM);
                A_SPEND:   st_d.ip = (st_q.ip & ~S_PEND_WM) | (wr_data[IRQ_W-1:0] & S_PEND_WM);
                A_MENABLE: st_d.ie = (st_q.ie & ~EN_WM)     | (wr_data[IRQ_W-1:0] & EN_WM);
                A_SENABLE: st_d.ie = (st_q.ie & ~S_VIEW_M)  | (wr_data[IRQ_W-1:0] & S_VIEW_M);
                A_STVEC:   st_d.tvec = {wr_data[XLEN-1:2], 2'b00};
                A_HOST:    if (st_q.host == '0) st_d.host = wr_data;
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= RST_STATUS;
            st_q.ie     <= '0;
            st_q.ip     <= '0;
            st_q.tvec   <= '0;
            st_q.host   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/csrw_unit_chk.sv
module csrw_unit_chk
    import csrw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  status,
    input logic [IRQ_W-1:0] ie,
    input logic [IRQ_W-1:0] ip,
    input logic [XLEN-1:0]  tvec,
    input logic [XLEN-1:0]  host,
    input logic [XLEN-1:0]  rd_data,
    input logic             rd_illegal
);

    logic [VM_W-1:0] vm;
    logic            vm_legal;
    assign vm = status[B_VM +: VM_W];
    assign vm_legal = (vm == VM_BARE) ||
                      ((XLEN == 32) ? (vm == VM_PG32) : (vm == VM_PG39 || vm == VM_PG48));

    a_r2_prv_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_PRV +: 2] != 2'd2 && status[B_PRV1 +: 2] != 2'd2 && status[B_PRV2 +: 2] != 2'd2);

    a_r3_vm_legal: assert property (@(posedge clk) disable iff (!rst_n) vm_legal);

    a_r4_dirty_sum: assert property (@(posedge clk) disable iff (!rst_n)
        status[XLEN-1] == ((status[B_FS +: 2] == 2'b11) || (status[B_XS +: 2] == 2'b11)));

    a_r5_pend_mask: assert property (@(posedge clk) disable iff (!rst_n) (ip & ~PEND_WM) == '0);

    a_r6_en_mask: assert property (@(posedge clk) disable iff (!rst_n) (ie & ~EN_WM) == '0);

    a_r9_tvec_align: assert property (@(posedge clk) disable iff (!rst_n) tvec[1:0] == 2'b00);

    a_r10_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host != '0) |=> $stable(host));

    a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_data == '0));

endmodule

bind csrw_unit csrw_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .status(status_q), .ie(ie_q), .ip(ip_q),
    .tvec(tvec_q), .host(host_q), .rd_data(rd_data), .rd_illegal(rd_illegal)
);

// File: tb/csrw_unit_test.sv
`timescale 1ns/1ps
module csrw_unit_test;

    localparam int XLEN = 64;
    localparam logic [63:0] SD = 64'h8000_0000_0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [11:0]     wr_addr = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic [11:0]     rd_addr = '0;
    logic [XLEN-1:0] rd_data;
    logic            rd_illegal;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    csrw_unit #(.XLEN(XLEN), .HAS_EXT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_illegal(rd_illegal)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [63:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
        check({tag, " flag"}, {63'd0, rd_illegal}, 64'd0);
    endtask

    task automatic t_reset;
        rd_chk("R1 status", 12'h100, 64'h96);
        rd_chk("R1 enable", 12'h104, 64'h0);
        rd_chk("R1 pending", 12'h108, 64'h0);
        rd_chk("R1 tvec", 12'h01C, 64'h0);
        rd_chk("R1 host", 12'h120, 64'h0);
    endtask

    task automatic t_prv;
        wr(12'h100, 64'h185);
        rd_chk("R2 illegal prv kept", 12'h100, 64'h187);
    endtask

    task automatic t_vm;
        wr(12'h100, 64'h120187);
        rd_chk("R3 vm 9 taken", 12'h100, 64'h120187);
        wr(12'h100, 64'h100187);
        rd_chk("R3 vm 8 refused", 12'h100, 64'h120187);
        wr(12'h100, 64'h3E0187);
        rd_chk("R3 vm 31 refused", 12'h100, 64'h120187);
        wr(12'h100, 64'h140187);
        rd_chk("R3 vm 10 taken", 12'h100, 64'h140187);
        wr(12'h100, 64'h187);
        rd_chk("R3 vm bare", 12'h100, 64'h187);
    endtask

    task automatic t_dirty;
        wr(12'h100, 64'h3187);
        rd_chk("R4 fs dirty", 12'h100, SD | 64'h3187);
        wr(12'h100, 64'h1187);
        rd_chk("R4 fs clean", 12'h100, 64'h1187);
        wr(12'h100, 64'hC187);
        rd_chk("R4 R12 xs dirty", 12'h100, SD | 64'hC187);
        wr(12'h100, SD | 64'h187);
        rd_chk("R4 sd write ignored", 12'h100, 64'h187);
    endtask

    task automatic t_sstatus;
        wr(12'h010, 64'h12008);
        rd_chk("R8 mstatus via sview", 12'h100, 64'h1218E);
        rd_chk("R8 sview read", 12'h010, 64'h12008);
        wr(12'h010, 64'h3010);
        rd_chk("R8 R12 mstatus ps", 12'h100, SD | 64'h3196);
        rd_chk("R8 sview read sd", 12'h010, SD | 64'h3010);
    endtask

    task automatic t_irq;
        wr(12'h108, '1);
        rd_chk("R5 pending mask", 12'h108, 64'h2A);
        wr(12'h104, '1);
        rd_chk("R6 enable mask", 12'h104, 64'hAA);
        wr(12'h108, 64'h0);
        wr(12'h018, '1);
        rd_chk("R7 spend write", 12'h108, 64'h02);
        wr(12'h108, 64'h2A);
        rd_chk("R7 spend read", 12'h018, 64'h22);
        wr(12'h104, 64'h0);
        wr(12'h014, '1);
        rd_chk("R7 senable write", 12'h104, 64'h22);
        wr(12'h104, '1);
        rd_chk("R7 senable read", 12'h014, 64'h22);
    endtask

    task automatic t_tvec;
        wr(12'h01C, 64'h1237);
        rd_chk("R9 tvec align", 12'h01C, 64'h1234);
    endtask

    task automatic t_host;
        wr(12'h120, 64'h0);
        rd_chk("R10 host zero", 12'h120, 64'h0);
        wr(12'h120, 64'h55);
        rd_chk("R10 host first", 12'h120, 64'h55);
        wr(12'h120, 64'h99);
        rd_chk("R10 host held", 12'h120, 64'h55);
    endtask

    task automatic t_illegal;
        wr(12'h7FF, '1);
        @(negedge clk);
        rd_addr = 12'h7FF;
        #1;
        check("R11 illegal flag", {63'd0, rd_illegal}, 64'd1);
        check("R11 illegal data", rd_data, 64'h0);
        rd_addr = 12'h101;
        #1;
        check("R11 near address", {63'd0, rd_illegal}, 64'd1);
        rd_chk("R11 status intact", 12'h100, SD | 64'h3196);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_prv;
        t_vm;
        t_dirty;
        t_sstatus;
        t_irq;
        t_tvec;
        t_host;
        t_illegal;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule